// File: doc/BRIEF.md
# Group Line-Buffer Direction and Tristate Controller

This block sits beside one 24-line digital I/O group. It watches the write bus for stores to that group's port-control register and derives two things from them. The first is a drive-outward flag for each of the group's four ports: the two byte-wide ports A and B, and the high and low nibbles of port C. The second is a single enable for all of the group's line buffers. Direction follows the direction bits of the most recent configuration byte. A configuration byte is a control write with bit 7 set.

Bit 7 of every control write is also a tristate flag. A mode-set write (bit 7 high) tristates the buffers. Software then loads the output data while the lines float. It then repeats the same byte with bit 7 low, which opens the buffers and leaves the port configuration as it is. A static jumper input selects the always-enabled option, which keeps the buffers enabled whatever bit 7 says.

The enable logic is a three-state machine, and the state register changes only on the clock edge that samples a hit:

- GS_RX_IDLE: the state after reset. No configuration has been written yet, all ports point inward, and the buffers are tristated.
- GS_HELD: configured, with the buffers tristated.
- GS_OPEN: the buffers are enabled.

The transitions are:

- T_SET: a hit with bit 7 high. It goes from any state to GS_HELD.
- T_OPEN: a hit with bit 7 low. It goes from any state to GS_OPEN.
- T_STAY: there is no hit. The state is kept.

Top module: `grp_buf_ctl`

## Requirements
- R1: While reset is asserted, and after it is released, all four drive flags are 0 (all ports inward). `buf_en` equals `perm_en`: the enable flag starts in the tristated state.
- R2: A hit is `wr_en`=1 together with `wr_addr` = GROUP_IDX*4+3. A hit with `wr_data[7]`=1 sets `drv_a`=~d[4], `drv_b`=~d[1], `drv_chi`=~d[3] and `drv_clo`=~d[0]. A data bit of 1 means input and 0 means output.
- R3: A hit with `wr_data[7]`=1 makes `buf_en` 0 when `perm_en`=0.
- R4: A hit with `wr_data[7]`=0 makes `buf_en` 1 and leaves all four drive flags unchanged.
- R5: While `perm_en`=1, `buf_en` is 1 in every cycle, whatever bit 7 of the control writes says.
- R6: A write to any other address, or a cycle with `wr_en`=0, changes neither the drive flags nor the enable state.
- R7: The drive flags and the enable state change on the rising clock edge that samples the hit, and not before that edge.
- R8: Data bits 2, 5 and 6 of a control write have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (5) | Register offset of the write |
| wr_data | input | 8 | Write data byte |
| perm_en | input | 1 | Jumper: 1 = buffers always enabled, 0 = software tristate |
| drv_a | output | 1 | Port A buffers drive outward |
| drv_b | output | 1 | Port B buffers drive outward |
| drv_chi | output | 1 | Port C upper-nibble buffers drive outward |
| drv_clo | output | 1 | Port C lower-nibble buffers drive outward |
| buf_en | output | 1 | Group buffer enable (0 = tristate) |

## Verification
The assertions check on every cycle the following behaviours:

- the bit mapping of a mode-set hit onto the four drive flags;
- the tristate that follows a bit-7-high hit;
- the opening that follows a bit-7-low hit, with the directions held;
- the permanent-enable override;
- the stability of the direction flags in cycles with no hit.

The bench scenarios show the remaining behaviours. These are the reset values, the lack of any change before the capturing edge, and the lack of any effect from the ignored mode bits 2, 5 and 6. They also include the full configure, load and open sequence, and writes aimed at another group's control offset.

// File: rtl/gbc_pkg.sv
package gbc_pkg;

    typedef enum logic [1:0] {
        GS_RX_IDLE = 2'd0,
        GS_HELD    = 2'd1,
        GS_OPEN    = 2'd2
    } gbc_state_t;

    localparam int unsigned NUM_PORTS  = 4;
    localparam int unsigned TRI_BIT    = 7;

    // direction bit position per port: A, B, C-high, C-low
    function automatic int unsigned dir_pos(input int unsigned port);
        case (port)
            0:       return 4;
            1:       return 1;
            2:       return 3;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/gbc_dir_reg.sv
module gbc_dir_reg #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned PORTS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] cfg,
    output logic [PORTS-1:0]  drive_out
);
    import gbc_pkg::*;

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        localparam int unsigned POS = dir_pos(p);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                drive_out[p] <= 1'b0;
            end else if (load) begin
                drive_out[p] <= ~cfg[POS];
            end
        end
    end

endmodule

// File: rtl/gbc_en_fsm.sv
module gbc_en_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic tri_flag,
    input  logic perm_en,
    output logic buf_en
);
    import gbc_pkg::*;

    gbc_state_t state_q;
    gbc_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_RX_IDLE, GS_HELD, GS_OPEN: begin
                if (hit) begin
                    state_d = tri_flag ? GS_HELD : GS_OPEN;
                end
            end
            default: state_d = GS_RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GS_RX_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        buf_en = perm_en;
        unique case (state_q)
            GS_OPEN:             buf_en = 1'b1;
            GS_RX_IDLE, GS_HELD: buf_en = perm_en;
            default:             buf_en = perm_en;
        endcase
    end

endmodule

// File: rtl/grp_buf_ctl.sv
module grp_buf_ctl #(
    parameter int unsigned ADDR_W         = 5,
    parameter int unsigned GROUP_IDX      = 0,
    parameter int unsigned REGS_PER_GROUP = 4,
    parameter int unsigned CTL_SLOT       = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              perm_en,
    output logic              drv_a,
    output logic              drv_b,
    output logic              drv_chi,
    output logic              drv_clo,
    output logic              buf_en
);
    import gbc_pkg::*;

    localparam int unsigned CTL_OFFSET = GROUP_IDX * REGS_PER_GROUP + CTL_SLOT;
    localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(CTL_OFFSET);

    logic                 hit;
    logic [NUM_PORTS-1:0] drive_vec;

    assign hit = wr_en && (wr_addr == CTL_ADDR);

    gbc_dir_reg #(
        .DATA_W (8),
        .PORTS  (NUM_PORTS)
    ) u_dir (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (hit && wr_data[TRI_BIT]),
        .cfg       (wr_data),
        .drive_out (drive_vec)
    );

    gbc_en_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .tri_flag (wr_data[TRI_BIT]),
        .perm_en  (perm_en),
        .buf_en   (buf_en)
    );

    assign drv_a   = drive_vec[0];
    assign drv_b   = drive_vec[1];
    assign drv_chi = drive_vec[2];
    assign drv_clo = drive_vec[3];

endmodule

// File: rtl/grp_buf_ctl_chk.sv
module grp_buf_ctl_chk #(
    parameter int unsigned ADDR_W   = 5,
    parameter int unsigned CTL_OFFS = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_data,
    input logic              perm_en,
    input logic              drv_a,
    input logic              drv_b,
    input logic              drv_chi,
    input logic              drv_clo,
    input logic              buf_en
);
    logic own;
    assign own = wr_en && (wr_addr == ADDR_W'(CTL_OFFS));

    // R2
    dir_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (own && wr_data[7]) |=> (drv_a == !$past(wr_data[4]) && drv_b == !$past(wr_data[1])
                                 && drv_chi == !$past(wr_data[3]) && drv_clo == !$past(wr_data[0])));

    // R3
    tri_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (own && wr_data[7] && !perm_en) |=> (!buf_en || perm_en));

    // R4
    open_keep_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (own && !wr_data[7]) |=> (buf_en && $stable({drv_a, drv_b, drv_chi, drv_clo})));

    // R5
    perm_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        perm_en |-> buf_en);

    // R6
    no_hit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !own |=> $stable({drv_a, drv_b, drv_chi, drv_clo}));

endmodule

bind grp_buf_ctl grp_buf_ctl_chk #(
    .ADDR_W   (ADDR_W),
    .CTL_OFFS (CTL_OFFSET)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .perm_en (perm_en),
    .drv_a   (drv_a),
    .drv_b   (drv_b),
    .drv_chi (drv_chi),
    .drv_clo (drv_clo),
    .buf_en  (buf_en)
);

// File: tb/test_grp_buf_ctl.sv
module test_grp_buf_ctl;
    localparam int CLK_PERIOD = 10;
    localparam int GROUP      = 1;
    localparam logic [4:0] OWN   = 5'(GROUP * 4 + 3);
    localparam logic [4:0] OTHER = 5'd3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       perm_en = 1'b0;
    logic       drv_a, drv_b, drv_chi, drv_clo, buf_en;

    int n_cmp = 0;
    int n_bad = 0;
    logic [3:0] exp_drv = 4'b0;
    logic       exp_open = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    grp_buf_ctl #(.ADDR_W(5), .GROUP_IDX(GROUP)) i_grp_buf_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .perm_en(perm_en), .drv_a(drv_a), .drv_b(drv_b),
        .drv_chi(drv_chi), .drv_clo(drv_clo), .buf_en(buf_en)
    );

    function automatic logic [3:0] f_drv(input logic [7:0] d);
        return {~d[0], ~d[3], ~d[1], ~d[4]};
    endfunction

    function automatic logic f_en(input logic perm, input logic open);
        return perm | open;
    endfunction

    task automatic compare(input string req);
        n_cmp++;
        if ({drv_clo, drv_chi, drv_b, drv_a} !== exp_drv) begin
            n_bad++;
            $display("FAIL %s drive: actual %b expected %b", req,
                     {drv_clo, drv_chi, drv_b, drv_a}, exp_drv);
        end
        n_cmp++;
        if (buf_en !== f_en(perm_en, exp_open)) begin
            n_bad++;
            $display("FAIL %s buf_en: actual %b expected %b", req, buf_en,
                     f_en(perm_en, exp_open));
        end
    endtask

    // entered at a negedge, leaves at the next negedge
    task automatic cycle(input logic en, input logic [4:0] a, input logic [7:0] d,
                         input logic perm, input string req);
        wr_en = en; wr_addr = a; wr_data = d; perm_en = perm;
        #1;
        compare("R7 pre-edge");
        @(posedge clk);
        if (en && a == OWN) begin
            if (d[7]) begin
                exp_drv  = f_drv(d);
                exp_open = 1'b0;
            end else begin
                exp_open = 1'b1;
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
        compare(req);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        @(negedge clk);
        compare("R1 in reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after reset");

        cycle(1'b1, OWN, 8'h89, 1'b0, "R2 R3 mode-set 89");
        cycle(1'b1, OWN, 8'h09, 1'b0, "R4 open 09");
        cycle(1'b1, OTHER, 8'hFF, 1'b0, "R6 other group");
        cycle(1'b0, OWN, 8'h80, 1'b0, "R6 strobe low");
        cycle(1'b1, OWN, 8'hE4, 1'b0, "R8 ignored bits E4");
        cycle(1'b1, OWN, 8'h80, 1'b0, "R8 compare 80");
        cycle(1'b1, OWN, 8'h1B, 1'b0, "R4 open keeps dir");
        cycle(1'b1, OWN, 8'h98, 1'b1, "R5 perm with bit7");
        cycle(1'b1, OWN, 8'h18, 1'b1, "R5 perm open");

        for (int i = 0; i < 400; i++) begin
            logic [4:0] a;
            case ($urandom % 4)
                0, 1:    a = OWN;
                2:       a = OTHER;
                default: a = 5'($urandom);
            endcase
            cycle(1'($urandom), a, 8'($urandom), (i >= 200), "R2 R3 R4 R5 R6 random");
        end

        perm_en = 1'b1;
        rst_n = 1'b0;
        exp_drv = 4'b0;
        exp_open = 1'b0;
        #1;
        compare("R1 reset perm");
        @(negedge clk);
        rst_n = 1'b1;
        cycle(1'b0, OWN, 8'h00, 1'b0, "R1 idle tristated");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule